// File: doc/BRIEF.md
# Packed Instruction Fetch Expander

This block sits between the instruction fetch stage and the decoder. Each cycle it may take one 32-bit fetched word. A packed word is expanded into a stream of instructions, issued one per cycle. Those instructions come from a 32-entry instruction register file that software loads ahead of time. While a pack still has instructions to issue, the block stalls fetch. A second 32-entry table holds 16-bit immediates, which a parameter slot can substitute into a register-file instruction.

Two packed forms exist. A tight word, marked by a reserved opcode, names up to five register-file entries. A loose word is an ordinary R-type or I-type instruction that gives up a few bits to carry one extra register-file index. The host instruction issues first and the referenced entry follows it. Jumps, jump-and-link and load-upper-immediate words pass through unchanged. A taken branch or a pipeline flush, both signalled on one redirect input, drops whatever is left of the current pack.

Top module: `pkt_expander`

## Requirements
- R1: During and right after reset, with no word yet accepted, issue_valid_o and stall_o are 0.
- R2: A tight word (opcode 6'h3E) has slots inst1=[25:21], inst2=[20:16], inst3=[15:11], inst4=[10:6], mode bit s=[5] and inst5=[4:0]. With s=0 it issues the register-file entry of each nonzero slot, in slot order, one per cycle. The first one appears on the cycle after the word is accepted, and zero slots are skipped.
- R3: stall_o is 1 while a pack has slots left to issue. It is 0 on the cycle the last slot appears on issue_insn_o. A word presented while stall_o is 1 is not taken. A tight word whose slots are all zero issues nothing and does not stall.
- R4: With s=1, only inst1 to inst3 issue. Slot [10:6] is a parameter for inst2 and slot [4:0] is a parameter for inst3. For a non-branch I-type entry, the parameter replaces the entry's low 16 bits with the immediate table word it indexes.
- R5: For an entry with opcode 1, 4, 5, 6 or 7 (a branch), a parameter instead replaces the low 16 bits with the 5-bit parameter itself, sign-extended, as the displacement.
- R6: An entry with opcode 0, 2 or 3 issues unchanged even when a parameter belongs to it.
- R7: A word with opcode 0 (R-type) issues {word[31:11], 5'b0, word[10:5]}. If word[4:0] is nonzero, register-file entry word[4:0] issues on the next cycle.
- R8: Any other non-tight opcode except 2, 3 and 6'h0F is a loose I-type word. It issues {word[31:16], sign-extended word[15:5] as 16 bits}. If word[4:0] is nonzero, entry word[4:0] follows on the next cycle.
- R9: Words with opcode 2, 3 or 6'h0F issue once, unchanged, with no stall.
- R10: While redirect_i is 1, stall_o is 0 and the fetched word is not taken. On the next cycle issue_valid_o is 0 and no remaining slot of the pack ever issues.
- R11: A write through either write port takes effect on the clock edge. Register-file entry 0 always reads as the all-zero nop, even after a write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetched word is presented |
| fetch_word_i | input | 32 | Fetched word |
| redirect_i | input | 1 | Taken branch or flush; drops the current pack |
| stall_o | output | 1 | Hold fetch and PC |
| irf_we_i | input | 1 | Register-file write enable |
| irf_waddr_i | input | 5 | Register-file write index |
| irf_wdata_i | input | 32 | Register-file write data |
| imm_we_i | input | 1 | Immediate table write enable |
| imm_waddr_i | input | 5 | Immediate table write index |
| imm_wdata_i | input | 16 | Immediate table write data |
| issue_valid_o | output | 1 | An instruction is issued to decode |
| issue_insn_o | output | 32 | Issued instruction (zero when not valid) |

## Verification
The bench checks that zero slots in the middle of a tight word are skipped. A design that issued them would leak nops and keep stall_o high one cycle too long. It checks the parameter mode, where the parameters must go to inst2 and inst3 and must patch an I-type entry, a branch entry and an R-type entry each in its own way. A design that mixed up the sign extension or the slot pairing would issue wrong low halves. It checks that lui and jump words are not treated as loose words even though their low bits look like an index, that a word held at the fetch port during a stall is taken only after the pack ends, and that a redirect mid-pack silences the output at once instead of letting the rest of the pack issue.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned SLOTS  = 5;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned REGS   = 1 << IDX_W;

  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_RTYPE = 6'h00;
  localparam op_t OP_J     = 6'h02;
  localparam op_t OP_JAL   = 6'h03;
  localparam op_t OP_LUI   = 6'h0F;

  typedef struct packed {
    logic                        lit_v;
    logic [INSN_W-1:0]           lit;
    logic [SLOTS-1:0]            mask;
    logic [SLOTS-1:0][IDX_W-1:0] idx;
    logic [SLOTS-1:0]            pv;
    logic [SLOTS-1:0][IDX_W-1:0] par;
  } pack_t;

  function automatic logic op_is_itype(op_t op);
    return !(op == OP_RTYPE || op == OP_J || op == OP_JAL);
  endfunction

  function automatic logic op_is_branch(op_t op);
    return op == 6'h01 || (op >= 6'h04 && op <= 6'h07);
  endfunction
endpackage

// File: rtl/pkt_regfile.sv
module pkt_regfile #(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned WIDTH     = 32,
  parameter bit          ZERO_LOW  = 1'b0,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  generate
    if (ZERO_LOW) begin : g_zero
      // entry 0 is the hard-wired nop
      assign rdata_o = (raddr_i == '0) ? '0 : mem_q[raddr_i];
    end else begin : g_plain
      assign rdata_o = mem_q[raddr_i];
    end
  endgenerate
endmodule

// File: rtl/pkt_decode.sv
module pkt_decode
  import pkt_pkg::*;
#(
  parameter op_t TIGHT_OP = 6'h3E
) (
  input  logic [INSN_W-1:0] word_i,
  output pack_t             pack_o
);
  op_t op;
  assign op = word_i[31:26];

  always_comb begin
    pack_o = '0;
    if (op == TIGHT_OP) begin
      pack_o.idx[0] = word_i[25:21];
      pack_o.idx[1] = word_i[20:16];
      pack_o.idx[2] = word_i[15:11];
      if (word_i[5]) begin
        pack_o.pv[1]  = 1'b1;
        pack_o.par[1] = word_i[10:6];
        pack_o.pv[2]  = 1'b1;
        pack_o.par[2] = word_i[4:0];
      end else begin
        pack_o.idx[3] = word_i[10:6];
        pack_o.idx[4] = word_i[4:0];
      end
      for (int i = 0; i < SLOTS; i++) pack_o.mask[i] = |pack_o.idx[i];
    end else if (op == OP_J || op == OP_JAL || op == OP_LUI) begin
      pack_o.lit_v = 1'b1;
      pack_o.lit   = word_i;
    end else begin
      pack_o.lit_v = 1'b1;
      if (op == OP_RTYPE)
        pack_o.lit = {word_i[31:11], {IDX_W{1'b0}}, word_i[10:5]};
      else
        pack_o.lit = {word_i[31:16], {IDX_W{word_i[15]}}, word_i[15:IDX_W]};
      pack_o.idx[0]  = word_i[4:0];
      pack_o.mask[0] = |word_i[4:0];
    end
  end
endmodule

// File: rtl/pkt_select.sv
module pkt_select
  import pkt_pkg::*;
(
  input  logic              lit_v_i,
  input  logic [SLOTS-1:0]  mask_i,
  output logic              pick_v_o,
  output logic              pick_lit_o,
  output logic [SLOT_W-1:0] pick_slot_o,
  output logic [SLOTS-1:0]  rest_mask_o
);
  logic found;

  always_comb begin
    pick_lit_o  = lit_v_i;
    pick_v_o    = lit_v_i | (|mask_i);
    pick_slot_o = '0;
    rest_mask_o = mask_i;
    found       = 1'b0;
    if (!lit_v_i) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (mask_i[i] && !found) begin
          found          = 1'b1;
          pick_slot_o    = SLOT_W'(i);
          rest_mask_o[i] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_patch.sv
module pkt_patch
  import pkt_pkg::*;
(
  input  logic [INSN_W-1:0] entry_i,
  input  logic              pv_i,
  input  logic [IDX_W-1:0]  par_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [INSN_W-1:0] insn_o
);
  op_t op;
  assign op = entry_i[31:26];

  always_comb begin
    if (!pv_i || !op_is_itype(op))
      insn_o = entry_i;
    else if (op_is_branch(op))
      insn_o = {entry_i[INSN_W-1:IMM_W], {(IMM_W-IDX_W){par_i[IDX_W-1]}}, par_i};
    else
      insn_o = {entry_i[INSN_W-1:IMM_W], imm_i};
  end
endmodule

// File: rtl/pkt_expander.sv
module pkt_expander
  import pkt_pkg::*;
#(
  parameter op_t TIGHT_OP = 6'h3E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [INSN_W-1:0] fetch_word_i,
  input  logic              redirect_i,
  output logic              stall_o,
  input  logic              irf_we_i,
  input  logic [IDX_W-1:0]  irf_waddr_i,
  input  logic [INSN_W-1:0] irf_wdata_i,
  input  logic              imm_we_i,
  input  logic [IDX_W-1:0]  imm_waddr_i,
  input  logic [IMM_W-1:0]  imm_wdata_i,
  output logic              issue_valid_o,
  output logic [INSN_W-1:0] issue_insn_o
);
  pack_t pend_q, dec, src, rest;
  logic  pend_busy, take;
  logic  pick_v, pick_lit;
  logic [SLOT_W-1:0] pick_slot;
  logic [SLOTS-1:0]  rest_mask;
  logic [INSN_W-1:0] irf_rdata, patched, cand;
  logic [IMM_W-1:0]  imm_rdata;

  pkt_decode #(.TIGHT_OP(TIGHT_OP)) u_decode (
    .word_i (fetch_word_i),
    .pack_o (dec)
  );

  assign pend_busy = pend_q.lit_v | (|pend_q.mask);
  assign src       = pend_busy ? pend_q : dec;
  assign take      = !redirect_i && (pend_busy || fetch_valid_i);
  assign stall_o   = pend_busy & ~redirect_i;

  pkt_select u_select (
    .lit_v_i     (src.lit_v),
    .mask_i      (src.mask),
    .pick_v_o    (pick_v),
    .pick_lit_o  (pick_lit),
    .pick_slot_o (pick_slot),
    .rest_mask_o (rest_mask)
  );

  pkt_regfile #(.DEPTH(REGS), .WIDTH(INSN_W), .ZERO_LOW(1'b1)) u_irf (
    .clk_i   (clk_i),
    .we_i    (irf_we_i),
    .waddr_i (irf_waddr_i),
    .wdata_i (irf_wdata_i),
    .raddr_i (src.idx[pick_slot]),
    .rdata_o (irf_rdata)
  );

  pkt_regfile #(.DEPTH(REGS), .WIDTH(IMM_W), .ZERO_LOW(1'b0)) u_imm (
    .clk_i   (clk_i),
    .we_i    (imm_we_i),
    .waddr_i (imm_waddr_i),
    .wdata_i (imm_wdata_i),
    .raddr_i (src.par[pick_slot]),
    .rdata_o (imm_rdata)
  );

  pkt_patch u_patch (
    .entry_i (irf_rdata),
    .pv_i    (src.pv[pick_slot]),
    .par_i   (src.par[pick_slot]),
    .imm_i   (imm_rdata),
    .insn_o  (patched)
  );

  assign cand = pick_lit ? src.lit : patched;

  always_comb begin
    rest       = src;
    rest.lit_v = 1'b0;
    rest.mask  = rest_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= '0;
      issue_valid_o <= 1'b0;
      issue_insn_o  <= '0;
    end else if (redirect_i) begin
      pend_q        <= '0;
      issue_valid_o <= 1'b0;
      issue_insn_o  <= '0;
    end else if (take) begin
      pend_q        <= rest;
      issue_valid_o <= pick_v;
      issue_insn_o  <= pick_v ? cand : '0;
    end else begin
      issue_valid_o <= 1'b0;
      issue_insn_o  <= '0;
    end
  end
endmodule

// File: rtl/pkt_expander_chk.sv
module pkt_expander_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_valid_i,
  input logic [31:0] fetch_word_i,
  input logic        redirect_i,
  input logic        stall_o,
  input logic        issue_valid_o,
  input logic [31:0] issue_insn_o
);
  // a stalled cycle is always one in which a slot of the pack is on the output
  assert_stall_with_issue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> issue_valid_o);

  assert_redirect_silences_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !issue_valid_o);

  assert_redirect_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !stall_o);

  assert_jump_passthru_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !stall_o && !redirect_i && fetch_word_i[31:26] == 6'h02)
    |=> (issue_valid_o && !stall_o && issue_insn_o == $past(fetch_word_i)));
endmodule

bind pkt_expander pkt_expander_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fetch_word_i  (fetch_word_i),
  .redirect_i    (redirect_i),
  .stall_o       (stall_o),
  .issue_valid_o (issue_valid_o),
  .issue_insn_o  (issue_insn_o)
);

// File: tb/pkt_expander_tb_top.sv
module pkt_expander_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_word_i = '0;
  logic        redirect_i = 1'b0;
  logic        stall_o;
  logic        irf_we_i = 1'b0;
  logic [4:0]  irf_waddr_i = '0;
  logic [31:0] irf_wdata_i = '0;
  logic        imm_we_i = 1'b0;
  logic [4:0]  imm_waddr_i = '0;
  logic [15:0] imm_wdata_i = '0;
  logic        issue_valid_o;
  logic [31:0] issue_insn_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pkt_expander dut_i (.*);

  function automatic logic [31:0] entry_of(int i);
    case (i % 4)
      0: return {6'h00, 5'(i), 5'(i+1), 5'(i+2), 5'd0, 6'h21};
      1: return {6'h09, 5'(i), 5'(i), 16'h1000 + 16'(i)};
      2: return {6'h04, 5'(i), 5'd0, 16'h0040 + 16'(i)};
      default: return {6'h02, 26'(i)};
    endcase
  endfunction

  function automatic logic [15:0] imm_of(int k);
    return 16'hA000 | 16'(k * 3);
  endfunction

  function automatic logic [31:0] tight(int a, int b, int c, int d, int s, int e);
    return {6'h3E, 5'(a), 5'(b), 5'(c), 5'(d), 1'(s), 5'(e)};
  endfunction

  // expected entry after a parameter is applied (R4, R5, R6)
  function automatic logic [31:0] patched(int i, int p);
    logic [31:0] e;
    logic [5:0] op;
    logic [4:0] pp;
    e = entry_of(i);
    op = e[31:26];
    pp = 5'(p);
    if (op == 6'h00 || op == 6'h02 || op == 6'h03) return e;
    if (op == 6'h01 || (op >= 6'h04 && op <= 6'h07)) return {e[31:16], {11{pp[4]}}, pp};
    return {e[31:16], imm_of(p)};
  endfunction

  typedef struct packed {
    logic [31:0]      word;
    logic [2:0]       n;
    logic [0:4][31:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    // R2: all five slots in order
    '{word: tight(1,2,3,4,0,5), n: 3'd5,
      exp: '{entry_of(1), entry_of(2), entry_of(3), entry_of(4), entry_of(5)}},
    // R2: zero slots skipped
    '{word: tight(0,6,0,7,0,0), n: 3'd2, exp: '{entry_of(6), entry_of(7), 0, 0, 0}},
    // R3: all-nop tight word issues nothing
    '{word: tight(0,0,0,0,0,0), n: 3'd0, exp: '{0, 0, 0, 0, 0}},
    // R4 (I-type gets table value) and R5 (negative branch displacement)
    '{word: tight(5,9,2,7,1,20), n: 3'd3,
      exp: '{entry_of(5), patched(9,7), patched(2,20), 0, 0}},
    // R6 (R-type entry untouched) and R5 (positive displacement)
    '{word: tight(0,12,6,3,1,5), n: 3'd2, exp: '{patched(12,3), patched(6,5), 0, 0, 0}},
    // R7: loose R-type host then entry 9
    '{word: {6'h00, 5'd3, 5'd4, 5'd5, 6'h21, 5'd9}, n: 3'd2,
      exp: '{{6'h00, 5'd3, 5'd4, 5'd5, 5'd0, 6'h21}, entry_of(9), 0, 0, 0}},
    // R8: loose I-type, negative short immediate, no extra
    '{word: {6'h09, 5'd1, 5'd2, 11'h7F0, 5'd0}, n: 3'd1,
      exp: '{{6'h09, 5'd1, 5'd2, 16'hFFF0}, 0, 0, 0, 0}},
    // R8: loose I-type with extra entry 13
    '{word: {6'h23, 5'd4, 5'd5, 11'h012, 5'd13}, n: 3'd2,
      exp: '{{6'h23, 5'd4, 5'd5, 16'h0012}, entry_of(13), 0, 0, 0}},
    // R9: lui unchanged even with nonzero low bits
    '{word: {6'h0F, 5'd0, 5'd7, 16'hABCD}, n: 3'd1, exp: '{{6'h0F, 5'd0, 5'd7, 16'hABCD}, 0, 0, 0, 0}},
    // R9: jal unchanged
    '{word: {6'h03, 26'h3FFFFEF}, n: 3'd1, exp: '{{6'h03, 26'h3FFFFEF}, 0, 0, 0, 0}}
  };

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr_irf(int a, logic [31:0] d);
    @(negedge clk_i);
    irf_we_i = 1'b1; irf_waddr_i = 5'(a); irf_wdata_i = d;
    @(negedge clk_i);
    irf_we_i = 1'b0;
  endtask

  task automatic wr_imm(int a, logic [15:0] d);
    @(negedge clk_i);
    imm_we_i = 1'b1; imm_waddr_i = 5'(a); imm_wdata_i = d;
    @(negedge clk_i);
    imm_we_i = 1'b0;
  endtask

  task automatic run_pack(string tag, logic [31:0] w, int n, logic [0:4][31:0] exp);
    @(negedge clk_i);
    fetch_valid_i = 1'b1;
    fetch_word_i  = w;
    if (n == 0) begin
      @(negedge clk_i);
      check({tag, " empty valid"}, 32'(issue_valid_o), 32'd0);
      check({tag, " empty stall"}, 32'(stall_o), 32'd0);
      fetch_valid_i = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      check($sformatf("%s slot %0d valid", tag, k), 32'(issue_valid_o), 32'd1);
      check($sformatf("%s slot %0d insn", tag, k), issue_insn_o, exp[k]);
      check($sformatf("%s slot %0d stall", tag, k), 32'(stall_o), 32'(k < n - 1));
      fetch_valid_i = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: idle during reset
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", 32'(issue_valid_o), 32'd0);
    check("R1 reset stall", 32'(stall_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 post-reset valid", 32'(issue_valid_o), 32'd0);
    check("R1 post-reset stall", 32'(stall_o), 32'd0);

    for (int i = 1; i < 32; i++) wr_irf(i, entry_of(i));
    for (int k = 0; k < 32; k++) wr_imm(k, imm_of(k));

    for (int v = 0; v < NVEC; v++)
      run_pack($sformatf("vec%0d", v), VECS[v].word, int'(VECS[v].n), VECS[v].exp);

    // R3: word held at the port during a stall is taken only after the pack
    @(negedge clk_i);
    fetch_valid_i = 1'b1;
    fetch_word_i  = tight(1,2,0,0,0,0);
    @(negedge clk_i);
    check("R3 held slot0", issue_insn_o, entry_of(1));
    check("R3 held stall0", 32'(stall_o), 32'd1);
    fetch_word_i = {6'h03, 26'h0000123};
    @(negedge clk_i);
    check("R3 held slot1", issue_insn_o, entry_of(2));
    check("R3 held stall1", 32'(stall_o), 32'd0);
    @(negedge clk_i);
    check("R3 held next valid", 32'(issue_valid_o), 32'd1);
    check("R3 held next insn", issue_insn_o, {6'h03, 26'h0000123});
    fetch_valid_i = 1'b0;

    // R10: redirect in the middle of a pack
    @(negedge clk_i);
    fetch_valid_i = 1'b1;
    fetch_word_i  = tight(1,2,3,4,0,5);
    @(negedge clk_i);
    check("R10 pre slot0", issue_insn_o, entry_of(1));
    fetch_valid_i = 1'b0;
    @(negedge clk_i);
    check("R10 pre slot1", issue_insn_o, entry_of(2));
    redirect_i    = 1'b1;
    fetch_valid_i = 1'b1;
    fetch_word_i  = {6'h02, 26'h0000055};
    #1;
    check("R10 stall drop", 32'(stall_o), 32'd0);
    @(negedge clk_i);
    check("R10 after valid", 32'(issue_valid_o), 32'd0);
    check("R10 after stall", 32'(stall_o), 32'd0);
    redirect_i    = 1'b0;
    fetch_valid_i = 1'b0;
    @(negedge clk_i);
    check("R10 rest dropped", 32'(issue_valid_o), 32'd0);

    // R11: entry 0 stays nop, rewrites take effect
    wr_irf(0, 32'hDEADBEEF);
    wr_irf(1, 32'h24000077);
    run_pack("R11 zero", tight(0,0,0,0,0,0), 0, '{0, 0, 0, 0, 0});
    run_pack("R11 loose0", {6'h00, 5'd1, 5'd2, 5'd3, 6'h20, 5'd0}, 1,
             '{{6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 0, 0, 0, 0});
    @(negedge clk_i);
    check("R11 loose0 no extra", 32'(issue_valid_o), 32'd0);
    run_pack("R11 rewrite", tight(1,0,0,0,0,0), 1, '{32'h24000077, 0, 0, 0, 0});
    wr_imm(7, 16'h1234);
    run_pack("R11 imm", tight(0,9,0,7,1,0), 1, '{{entry_of(9)[31:16], 16'h1234}, 0, 0, 0, 0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule